// File: doc/BRIEF.md
# Dual-Rate PCM/ADPCM Serial Framing Port

This block is the serial edge of one voice transcoder channel. On the sample side, a frame pulse and a bit clock bring in an 8-bit companded sample, most significant bit first. Each completed sample is held and passed to an encoder stage through a parallel word. The encoder stage here is a stand-in that keeps only the top four bits, after it undoes the alternate-bit inversion of the A-law format. The sample then crosses into the code-side clock domain through a toggle handshake.

The code side has its own frame pulse and bit clock, which may differ in rate and phase from the sample side. On the rising edge of its frame pulse it loads a shift register. In normal mode the load is the 4-bit code. In through mode it is the raw 8-bit sample. It then drives the loaded bits out MSB first with an output enable, and releases the line once the last bit is gone. On the same framing, a 4-bit code word arriving on the code-side input is checked for the all-zero pattern. An active-low power-down input holds the whole channel idle.

Top module: `pcm_adpcm_port`

## Requirements
- R1: On the sample side, the bit present on the `pcm_bclk` rising edge where `pcm_sync` is high is sample bit 7. The next seven rising edges carry bits 6 down to 0.
- R2: With `thr` low at a code-side frame edge (a `pcm_bclk`-independent `adp_bclk` rising edge where `adp_sync` goes from low to high), `adp_oe` is high for exactly the next 4 `adp_bclk` cycles. During those cycles `adp_dout` carries the code, MSB first. With `a_law` low, the code is sample bits 7..4.
- R3: With `a_law` high, the code is bits 7..4 of the sample XOR 8'h55.
- R4: With `thr` high at the frame edge, `adp_oe` is high for exactly 8 cycles and `adp_dout` carries the raw sample, MSB first, whatever `a_law` is.
- R5: Outside those windows `adp_oe` is low and `adp_dout` is 0.
- R6: A frame edge with no new sample since the previous one loads the same stored sample again.
- R7: A sample completed on the sample side is used by any frame edge at least four `adp_bclk` rising edges later. This holds with unrelated clock rates.
- R8: While `pdn_n` is 0, `adp_oe` stays low, `zero_code` is 0, and incoming samples are discarded. After release, the stored sample is 8'h00.
- R9: The bit on `adp_din` at a frame edge is bit 3 of a received code word, and the next three edges carry bits 2..0. After the fourth bit, `zero_code` is 1 if the word was 0000 and 0 otherwise. It holds that value until the next word completes.
- R10: After reset, `adp_oe` and `zero_code` are 0 and the stored sample is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pcm_bclk | input | 1 | Sample-side bit clock |
| adp_bclk | input | 1 | Code-side bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pdn_n | input | 1 | Power-down, active low |
| a_law | input | 1 | 1 selects A-law, 0 selects µ-law |
| pcm_sync | input | 1 | Sample-side frame pulse |
| pcm_din | input | 1 | Serial sample input |
| adp_sync | input | 1 | Code-side frame pulse |
| thr | input | 1 | Through-mode select, sampled at the frame edge |
| adp_din | input | 1 | Serial code word input |
| adp_dout | output | 1 | Serial code or through output |
| adp_oe | output | 1 | Output enable; low means the line floats |
| zero_code | output | 1 | Last received code word was 0000 |

## Verification
Directed samples 8'h80 and 8'h01 separate a correct MSB-first capture from a reversed or shifted one. 8'h00 and 8'hFF show stuck bits. A sample sent under both companding settings shows whether the alternate-bit mask is applied, and whether it is applied only in coded mode. Random samples, modes and code words are mixed with repeated frames that carry no new sample, which shows stale-word reuse. The received code words include 0000, 1000 and 0001, which tells a full-word zero test from a test that looks at only one bit. A power-down pass shows that an incoming sample is dropped and that the line stays quiet.

// File: rtl/pcm_adpcm_port.sv
module pcm_adpcm_port #(
  parameter int PCM_W = 8,
  parameter int CODE_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic pcm_bclk,
  input  logic adp_bclk,
  input  logic rst_n,
  input  logic pdn_n,
  input  logic a_law,
  input  logic pcm_sync,
  input  logic pcm_din,
  input  logic adp_sync,
  input  logic thr,
  input  logic adp_din,
  output logic adp_dout,
  output logic adp_oe,
  output logic zero_code
);
  localparam int CW = $clog2(PCM_W + 1);
  localparam int RW = $clog2(CODE_W + 1);

  function automatic logic [PCM_W-1:0] alt_mask();
    logic [PCM_W-1:0] m;
    for (int i = 0; i < PCM_W; i++) m[i] = 1'((i % 2) == 0);
    return m;
  endfunction
  localparam logic [PCM_W-1:0] ALAW_MASK = alt_mask();

  // sample side
  logic [PCM_W-1:0] in_sh, held;
  logic [CW-1:0]    in_cnt;
  logic             in_tgl;

  always_ff @(posedge pcm_bclk or negedge rst_n)
    if (!rst_n || !pdn_n) begin
      in_sh <= '0; held <= '0; in_cnt <= '0; in_tgl <= 1'b0;
    end else if (pcm_sync) begin
      in_sh  <= {{(PCM_W-1){1'b0}}, pcm_din};
      in_cnt <= CW'(1);
    end else if (in_cnt != '0) begin
      in_sh <= {in_sh[PCM_W-2:0], pcm_din};
      if (in_cnt == CW'(PCM_W-1)) begin
        held   <= {in_sh[PCM_W-2:0], pcm_din};
        in_tgl <= ~in_tgl;
        in_cnt <= '0;
      end else begin
        in_cnt <= in_cnt + CW'(1);
      end
    end

  // crossing into code side
  logic [SYNC_STAGES:0] tsync;
  logic [PCM_W-1:0]     word;
  wire                  new_word = tsync[SYNC_STAGES] ^ tsync[SYNC_STAGES-1];

  always_ff @(posedge adp_bclk or negedge rst_n)
    if (!rst_n || !pdn_n) begin
      tsync <= '0; word <= '0;
    end else begin
      tsync <= {tsync[SYNC_STAGES-1:0], in_tgl};
      if (new_word) word <= held;
    end

  // encoder stand-in: parallel in, truncated code out
  wire [PCM_W-1:0]  enc_in  = a_law ? (word ^ ALAW_MASK) : word;
  wire [CODE_W-1:0] enc_out = enc_in[PCM_W-1 -: CODE_W];
  wire [PCM_W-1:0]  load_val = thr ? word : {enc_out, {(PCM_W-CODE_W){1'b0}}};

  // code side framing
  logic             sync_d;
  logic [PCM_W-1:0] tx_sh;
  logic [CW-1:0]    tx_rem;
  logic [CODE_W-1:0] rx_sh;
  logic [RW-1:0]    rx_cnt;
  wire              frame = adp_sync & ~sync_d;

  always_ff @(posedge adp_bclk or negedge rst_n)
    if (!rst_n || !pdn_n) begin
      sync_d <= 1'b0; tx_sh <= '0; tx_rem <= '0;
    end else begin
      sync_d <= adp_sync;
      if (frame) begin
        tx_sh  <= load_val;
        tx_rem <= thr ? CW'(PCM_W) : CW'(CODE_W);
      end else if (tx_rem != '0) begin
        tx_sh  <= tx_sh << 1;
        tx_rem <= tx_rem - CW'(1);
      end
    end

  always_ff @(posedge adp_bclk or negedge rst_n)
    if (!rst_n || !pdn_n) begin
      rx_sh <= '0; rx_cnt <= '0; zero_code <= 1'b0;
    end else if (frame) begin
      rx_sh  <= {{(CODE_W-1){1'b0}}, adp_din};
      rx_cnt <= RW'(1);
    end else if (rx_cnt != '0) begin
      rx_sh <= {rx_sh[CODE_W-2:0], adp_din};
      if (rx_cnt == RW'(CODE_W-1)) begin
        zero_code <= ({rx_sh[CODE_W-2:0], adp_din} == '0);
        rx_cnt    <= '0;
      end else begin
        rx_cnt <= rx_cnt + RW'(1);
      end
    end

  assign adp_oe   = (tx_rem != '0);
  assign adp_dout = adp_oe & tx_sh[PCM_W-1];
endmodule

// File: rtl/pcm_adpcm_port_chk.sv
module pcm_adpcm_port_chk (
  input logic adp_bclk,
  input logic rst_n,
  input logic pdn_n,
  input logic adp_sync,
  input logic adp_oe,
  input logic adp_dout
);
  logic [3:0] run;
  always_ff @(posedge adp_bclk or negedge rst_n)
    if (!rst_n) run <= '0;
    else if (!pdn_n || adp_sync) run <= '0;
    else if (adp_oe && run != 4'hF) run <= run + 4'd1;

  a_r8_pdn_quiet: assert property (@(posedge adp_bclk) disable iff (!rst_n)
    !pdn_n |=> !adp_oe);
  a_r2_oe_needs_sync: assert property (@(posedge adp_bclk) disable iff (!rst_n)
    $rose(adp_oe) |-> $past(adp_sync));
  a_r4_run_length: assert property (@(posedge adp_bclk) disable iff (!rst_n || !pdn_n)
    $fell(adp_oe) |-> (run == 4'd4 || run == 4'd8));
  a_r2_run_bound: assert property (@(posedge adp_bclk) disable iff (!rst_n)
    adp_oe |-> run <= 4'd7);
  a_r5_dout_known: assert property (@(posedge adp_bclk) disable iff (!rst_n)
    adp_oe |-> !$isunknown(adp_dout));
endmodule

bind pcm_adpcm_port pcm_adpcm_port_chk chk_i (
  .adp_bclk(adp_bclk), .rst_n(rst_n), .pdn_n(pdn_n),
  .adp_sync(adp_sync), .adp_oe(adp_oe), .adp_dout(adp_dout)
);

// File: tb/pcm_adpcm_port_tb_top.sv
module pcm_adpcm_port_tb_top;
  logic pcm_bclk = 0, adp_bclk = 0, rst_n = 0, pdn_n = 1, a_law = 0;
  logic pcm_sync = 0, pcm_din = 0, adp_sync = 0, thr = 0, adp_din = 0;
  wire  adp_dout, adp_oe, zero_code;
  int   n_cmp = 0, n_bad = 0;

  always #5 pcm_bclk = ~pcm_bclk;
  always #7 adp_bclk = ~adp_bclk;

  pcm_adpcm_port dut_i (
    .pcm_bclk(pcm_bclk), .adp_bclk(adp_bclk), .rst_n(rst_n), .pdn_n(pdn_n),
    .a_law(a_law), .pcm_sync(pcm_sync), .pcm_din(pcm_din), .adp_sync(adp_sync),
    .thr(thr), .adp_din(adp_din), .adp_dout(adp_dout), .adp_oe(adp_oe),
    .zero_code(zero_code));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_load(logic [7:0] w, logic t, logic al);
    logic [7:0] l;
    l = al ? (w ^ 8'h55) : w;
    return t ? w : {l[7:4], 4'b0000};
  endfunction

  task automatic send_pcm(logic [7:0] w);
    for (int i = 0; i < 8; i++) begin
      @(negedge pcm_bclk);
      pcm_sync = (i == 0);
      pcm_din  = w[7-i];
    end
    @(negedge pcm_bclk);
    pcm_sync = 0; pcm_din = 0;
    repeat (6) @(negedge adp_bclk);
  endtask

  task automatic adp_frame(logic t, logic [3:0] c, logic [7:0] ew, bit active, string req);
    int len;
    len = t ? 8 : 4;
    @(negedge adp_bclk);
    thr = t; adp_sync = 1; adp_din = c[3];
    for (int j = 0; j < 10; j++) begin
      @(negedge adp_bclk);
      adp_sync = 0;
      if (active && j < len) begin
        chk({req, " oe"}, {7'b0, adp_oe}, 8'h01);
        chk({req, " bit"}, {7'b0, adp_dout}, {7'b0, ew[7-j]});
      end else begin
        chk("R5 oe idle", {7'b0, adp_oe}, 8'h00);
        chk("R5 dout idle", {7'b0, adp_dout}, 8'h00);
      end
      adp_din = (j < 3) ? c[2-j] : 1'b0;
    end
    if (active) chk("R9 zero detect", {7'b0, zero_code}, {7'b0, c == 4'h0});
    else        chk("R8 zero cleared", {7'b0, zero_code}, 8'h00);
  endtask

  initial begin
    logic [7:0] w;
    logic t;
    logic [3:0] c;
    void'($urandom(32'd1234));
    repeat (3) @(negedge pcm_bclk);
    chk("R10 oe", {7'b0, adp_oe}, 8'h00);
    chk("R10 zero", {7'b0, zero_code}, 8'h00);
    rst_n = 1;
    repeat (3) @(negedge adp_bclk);
    adp_frame(1, 4'h5, 8'h00, 1, "R10 stored zero");

    a_law = 0;
    send_pcm(8'h80); adp_frame(1, 4'h0, 8'h80, 1, "R1 msb");
    send_pcm(8'h01); adp_frame(1, 4'h8, 8'h01, 1, "R1 lsb");
    send_pcm(8'hB7); adp_frame(0, 4'h1, exp_load(8'hB7, 0, 0), 1, "R2 code");
    adp_frame(1, 4'h0, 8'hB7, 1, "R6 reuse");
    adp_frame(0, 4'h0, exp_load(8'hB7, 0, 0), 1, "R6 reuse code");
    send_pcm(8'hFF); adp_frame(0, 4'hF, 8'hF0, 1, "R2 ones");
    a_law = 1;
    send_pcm(8'h3C); adp_frame(0, 4'h0, exp_load(8'h3C, 0, 1), 1, "R3 alaw");
    adp_frame(1, 4'h2, 8'h3C, 1, "R4 through alaw");
    send_pcm(8'h00); adp_frame(0, 4'h0, 8'h50, 1, "R3 alaw zero");

    for (int k = 0; k < 30; k++) begin
      w = 8'($urandom); t = 1'($urandom); a_law = 1'($urandom);
      c = ($urandom % 4 == 0) ? 4'h0 : 4'($urandom);
      send_pcm(w);
      adp_frame(t, c, exp_load(w, t, a_law), 1, t ? "R4 R7 rand" : "R2 R7 rand");
    end

    @(negedge adp_bclk); pdn_n = 0;
    send_pcm(8'hA5);
    adp_frame(1, 4'h0, 8'h00, 0, "R8 pdn");
    @(negedge adp_bclk); pdn_n = 1;
    repeat (6) @(negedge adp_bclk);
    adp_frame(1, 4'h0, 8'h00, 1, "R8 after pdn");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #3000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule